// File: doc/BRIEF.md
# Credit-Based Paired Proxy Thread Bank

This block is a bank of proxy threads, grouped in pairs. Within each pair one thread sends and the other receives. The direction of each thread is fixed at build time, and software can read it from the thread's control word. A sender fills a fifteen-word message window, and writing the final word hands the whole message to its partner's receive FIFO. A receiver reads the window, and reading the final word releases the message. Each released message returns one send credit to the partner.

The status word of every thread carries a count in its low byte and a sticky misuse flag in its top bit. On a sending thread the count is the number of credits left. On a receiving thread it is the number of messages waiting. Each receiving thread drives an interrupt line, which stays high while that thread has at least one message pending.

All access goes through a 32-bit word register port with a valid/ready handshake. Every accepted request, read or write, produces one response. A request is accepted only while the response stage is empty, or while its current response is being taken in that same cycle. A response holds its valid flag and its data unchanged until the requester raises `rsp_ready`.

Top module: `sp_bank`

## Requirements
- R1: After reset, each sending thread reports FIFO_DEPTH credits, each receiving thread reports 0 pending, every misuse flag is 0, and every interrupt line is low.
- R2: The control word is at region bit 1 with the thread's offset 0. Its bit 31 reads 1 for a receiving thread and 0 for a sending thread, and all other bits read 0. In the default build, threads 0 and 3 send, and threads 1 and 2 receive.
- R3: Data word i (0..14) is at thread offset 4+4*i, and the status word is at offset 0. Writing word 14 of a sending thread that has credit commits the message: its count drops by one and its partner's pending count rises by one.
- R4: A receiving thread returns the words of its oldest pending message, and messages come out in commit order. Reading word 14 consumes that message: pending drops by one and the partner gains one credit.
- R5: The interrupt line of a receiving thread is high exactly while its pending count is nonzero. The interrupt lines of sending threads stay low.
- R6: A commit with zero credits delivers nothing and sets bit 31 of the sending thread's status. Data words written while the sender has zero credits are dropped, and they do not alter any stored message.
- R7: Reading word 14 with zero pending returns 0, leaves both counts unchanged, and sets bit 31 of the receiving thread's status.
- R8: A misuse flag, once set, stays set until reset, while the count beside it keeps working.
- R9: `req_ready` equals `!rsp_valid || rsp_ready`. The response appears in the cycle after acceptance, and it stays valid and stable while `rsp_ready` is low.
- R10: Traffic on one pair leaves the counts, flags and interrupt lines of the other pair unchanged.
- R11: These accesses change no state: writes to status or control words, writes to a receiving thread's data, and any access whose byte address is not word aligned. Reads of a sending thread's data, and misaligned reads, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13+log2(2*NUM_PAIRS) | Byte address: [1:0] alignment, [11:2] word offset, then thread id, then region bit |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| rx_irq | output | 2*NUM_PAIRS | Per-thread interrupt, high while a receiving thread has pending messages |

## Verification
The hardest state to reach from the ports is a sender with no credits left that still receives a full message window. Getting there takes two complete messages queued without any reads. The stimulus then writes a third message whose words carry a distinct pattern, commits it, and drains the FIFO. Any leaked word would show up as corruption in the first queued message, because that message shares the write slot with the dropped message. Back-pressure is reached by holding `rsp_ready` low while a second request waits, so that acceptance and release happen on the same edge.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int DATA_W = 32;

  typedef enum logic {
    REG_DATA = 1'b0,
    REG_CTRL = 1'b1
  } region_e;

  typedef struct packed {
    region_e    region;
    logic       is_status;
    logic       is_data;
    logic [7:0] idx;
  } acc_t;
endpackage

// File: rtl/sp_decode.sv
module sp_decode
  import sp_pkg::*;
#(
  parameter int TID_W     = 2,
  parameter int MSG_WORDS = 15,
  localparam int ADDR_W   = 13 + TID_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [TID_W-1:0]  tid,
  output acc_t              dec
);
  logic [9:0] off;
  logic       aligned;

  always_comb begin
    off           = addr[11:2];
    aligned       = (addr[1:0] == 2'b00);
    tid           = addr[12 +: TID_W];
    dec.region    = region_e'(addr[12+TID_W]);
    dec.is_status = aligned && (off == 10'd0);
    dec.is_data   = aligned && (off != 10'd0) && (off <= 10'(MSG_WORDS));
    dec.idx       = dec.is_data ? 8'(off - 10'd1) : 8'd0;
  end
endmodule

// File: rtl/sp_pair.sv
module sp_pair
  import sp_pkg::*;
#(
  parameter int MSG_WORDS  = 15,
  parameter int FIFO_DEPTH = 2,
  parameter int CNT_W      = 8,
  parameter bit SWAP       = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              we,
  input  logic              lsel,
  input  acc_t              dec,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        irq
);
  localparam int TX_L  = SWAP ? 1 : 0;
  localparam int RX_L  = 1 - TX_L;
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int IDX_W = (MSG_WORDS > 1) ? $clog2(MSG_WORDS) : 1;
  localparam int LAST  = MSG_WORDS - 1;

  logic [DATA_W-1:0] mem [FIFO_DEPTH][MSG_WORDS];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  credit, pending;
  logic [1:0]        err;

  logic on_tx, data_acc, tx_wr, rx_rd, is_last, has_credit, has_msg;
  logic commit, consume, bad_commit, bad_consume;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    on_tx       = (lsel == 1'(TX_L));
    data_acc    = acc && (dec.region == REG_DATA) && dec.is_data;
    tx_wr       = data_acc && we && on_tx;
    rx_rd       = data_acc && !we && !on_tx;
    is_last     = (dec.idx == 8'(LAST));
    has_credit  = (credit != '0);
    has_msg     = (pending != '0);
    commit      = tx_wr && is_last && has_credit;
    bad_commit  = tx_wr && is_last && !has_credit;
    consume     = rx_rd && is_last && has_msg;
    bad_consume = rx_rd && is_last && !has_msg;
  end

  // message storage: words land straight in the tail slot while credit exists
  always_ff @(posedge clk) begin
    if (tx_wr && has_credit) mem[wr_ptr][dec.idx[IDX_W-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      credit  <= CNT_W'(FIFO_DEPTH);
      pending <= '0;
      err     <= '0;
    end else begin
      if (commit) begin
        wr_ptr  <= ptr_next(wr_ptr);
        credit  <= credit - CNT_W'(1);
        pending <= pending + CNT_W'(1);
      end else if (consume) begin
        rd_ptr  <= ptr_next(rd_ptr);
        pending <= pending - CNT_W'(1);
        credit  <= credit + CNT_W'(1);
      end
      if (bad_commit)  err[TX_L] <= 1'b1;
      if (bad_consume) err[RX_L] <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (dec.region == REG_CTRL) begin
      if (dec.is_status) rdata = {!on_tx, 31'b0};
    end else if (dec.is_status) begin
      rdata = {err[lsel], {(31-CNT_W){1'b0}}, on_tx ? credit : pending};
    end else if (dec.is_data && !on_tx && has_msg) begin
      rdata = mem[rd_ptr][dec.idx[IDX_W-1:0]];
    end
  end

  always_comb begin
    irq       = '0;
    irq[RX_L] = has_msg;
  end

  // R3/R4: credits and pending messages always sum to the FIFO depth
  a_r3_conserve: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, credit} + {1'b0, pending}) == (CNT_W+1)'(FIFO_DEPTH));
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    pending <= CNT_W'(FIFO_DEPTH));
  a_r5_irq_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> irq[RX_L]);
  a_r8_err_tx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err[TX_L] |=> err[TX_L]);
  a_r8_err_rx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err[RX_L] |=> err[RX_L]);
  a_r7_underflow_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    bad_consume |=> !irq[RX_L]);
endmodule

// File: rtl/sp_rsp.sv
module sp_rsp
  import sp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              take_ok
);
  assign take_ok = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= din;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  a_r9_load_valid: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rsp_valid);
endmodule

// File: rtl/sp_bank.sv
module sp_bank
  import sp_pkg::*;
#(
  parameter int          NUM_PAIRS  = 2,
  parameter int          MSG_WORDS  = 15,
  parameter int          FIFO_DEPTH = 2,
  parameter int          CNT_W      = 8,
  parameter int unsigned PAIR_SWAP  = 32'h2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic                                 req_write,
  input  logic [12+$clog2(2*NUM_PAIRS):0]      req_addr,
  input  logic [31:0]                          req_wdata,
  output logic                                 rsp_valid,
  input  logic                                 rsp_ready,
  output logic [31:0]                          rsp_rdata,
  output logic [2*NUM_PAIRS-1:0]               rx_irq
);
  localparam int NUM_THREADS = 2 * NUM_PAIRS;
  localparam int TID_W       = $clog2(NUM_THREADS);

  logic [TID_W-1:0]  tid, pidx;
  acc_t              dec;
  logic              acc;
  logic [DATA_W-1:0] pair_rd [NUM_PAIRS];
  logic [DATA_W-1:0] rd_mux;

  sp_decode #(.TID_W(TID_W), .MSG_WORDS(MSG_WORDS)) u_dec (
    .addr(req_addr), .tid(tid), .dec(dec)
  );

  assign acc  = req_valid && req_ready;
  assign pidx = tid >> 1;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    sp_pair #(
      .MSG_WORDS(MSG_WORDS), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W),
      .SWAP(((PAIR_SWAP >> p) & 32'd1) != 0)
    ) u_pair (
      .clk(clk), .rst_n(rst_n),
      .acc(acc && (pidx == TID_W'(p))),
      .we(req_write), .lsel(tid[0]), .dec(dec), .wdata(req_wdata),
      .rdata(pair_rd[p]), .irq(rx_irq[2*p +: 2])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PAIRS; p++)
      if (pidx == TID_W'(p)) rd_mux = pair_rd[p];
  end

  sp_rsp u_rsp (
    .clk(clk), .rst_n(rst_n), .load(acc),
    .din(req_write ? '0 : rd_mux),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .take_ok(req_ready)
  );
endmodule

// File: tb/test_sp_bank.sv
module test_sp_bank;
  localparam int ADDR_W = 15;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b1;
  logic [31:0]       rsp_rdata;
  logic [3:0]        rx_irq;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sp_bank i_sp_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rx_irq(rx_irq)
  );

  function automatic logic [ADDR_W-1:0] a_of(input int region, input int tid, input int off);
    return ADDR_W'((region << 14) | (tid << 12) | (off << 2));
  endfunction

  function automatic logic [31:0] word_of(input int seed, input int tid, input int i);
    return {8'(seed), 8'(tid), 8'(i), 8'hA5};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                     output logic [31:0] q);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    q = rsp_rdata;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    logic [31:0] q;
    bus(1'b1, a, d, q);
  endtask

  task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    logic [31:0] q;
    bus(1'b0, a, 32'h0, q);
    chk(req, q, exp);
  endtask

  task automatic send_msg(input int tid, input int seed);
    for (int i = 0; i < 15; i++) wr(a_of(0, tid, 1 + i), word_of(seed, tid, i));
  endtask

  task automatic recv_msg(input string req, input int rx, input int tx, input int seed);
    for (int i = 0; i < 15; i++) rd_chk(req, a_of(0, rx, 1 + i), word_of(seed, tx, i));
  endtask

  task automatic t_reset;
    rd_chk("R1 tx0 credits", a_of(0, 0, 0), 32'd2);
    rd_chk("R1 rx1 pending", a_of(0, 1, 0), 32'd0);
    rd_chk("R1 rx2 pending", a_of(0, 2, 0), 32'd0);
    rd_chk("R1 tx3 credits", a_of(0, 3, 0), 32'd2);
    chk("R1 irq low", 32'(rx_irq), 32'h0);
  endtask

  task automatic t_direction;
    rd_chk("R2 ctrl t0", a_of(1, 0, 0), 32'h0);
    rd_chk("R2 ctrl t1", a_of(1, 1, 0), 32'h8000_0000);
    rd_chk("R2 ctrl t2", a_of(1, 2, 0), 32'h8000_0000);
    rd_chk("R2 ctrl t3", a_of(1, 3, 0), 32'h0);
  endtask

  task automatic t_backpressure;
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a_of(0, 0, 0);
    @(negedge clk);
    req_addr = a_of(0, 1, 0);
    chk("R9 first rsp valid", 32'(rsp_valid), 32'd1);
    chk("R9 first rsp data", rsp_rdata, 32'd2);
    chk("R9 ready low while stalled", 32'(req_ready), 32'd0);
    repeat (3) @(negedge clk);
    chk("R9 rsp held", 32'(rsp_valid), 32'd1);
    chk("R9 data stable", rsp_rdata, 32'd2);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 second rsp valid", 32'(rsp_valid), 32'd1);
    chk("R9 second rsp data", rsp_rdata, 32'd0);
    @(negedge clk);
    chk("R9 drained", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_send;
    send_msg(0, 1);
    rd_chk("R3 tx0 credit after one", a_of(0, 0, 0), 32'd1);
    rd_chk("R3 rx1 pending after one", a_of(0, 1, 0), 32'd1);
    chk("R5 irq rx1", 32'(rx_irq), 32'h2);
    send_msg(0, 2);
    rd_chk("R3 tx0 credit after two", a_of(0, 0, 0), 32'd0);
    rd_chk("R3 rx1 pending after two", a_of(0, 1, 0), 32'd2);
  endtask

  task automatic t_overflow;
    send_msg(0, 3);
    rd_chk("R6 tx0 error set", a_of(0, 0, 0), 32'h8000_0000);
    rd_chk("R6 rx1 not delivered", a_of(0, 1, 0), 32'd2);
  endtask

  task automatic t_receive;
    recv_msg("R4 msg1 words", 1, 0, 1);
    rd_chk("R4 rx1 pending", a_of(0, 1, 0), 32'd1);
    rd_chk("R8 tx0 err kept, credit back", a_of(0, 0, 0), 32'h8000_0001);
    recv_msg("R4 msg2 order", 1, 0, 2);
    rd_chk("R4 rx1 empty", a_of(0, 1, 0), 32'd0);
    rd_chk("R8 tx0 credits full", a_of(0, 0, 0), 32'h8000_0002);
    chk("R5 irq low when empty", 32'(rx_irq), 32'h0);
  endtask

  task automatic t_underflow;
    rd_chk("R7 empty read zero", a_of(0, 1, 15), 32'h0);
    rd_chk("R7 rx1 error", a_of(0, 1, 0), 32'h8000_0000);
    rd_chk("R7 tx0 unchanged", a_of(0, 0, 0), 32'h8000_0002);
    send_msg(0, 4);
    recv_msg("R6 later message intact", 1, 0, 4);
    rd_chk("R8 rx1 err sticky", a_of(0, 1, 0), 32'h8000_0000);
  endtask

  task automatic t_pair_b;
    send_msg(3, 5);
    rd_chk("R10 rx2 pending", a_of(0, 2, 0), 32'd1);
    rd_chk("R10 tx3 credits", a_of(0, 3, 0), 32'd1);
    chk("R5 irq rx2", 32'(rx_irq), 32'h4);
    rd_chk("R10 rx1 untouched", a_of(0, 1, 0), 32'h8000_0000);
    rd_chk("R10 tx0 untouched", a_of(0, 0, 0), 32'h8000_0002);
    recv_msg("R4 pair b words", 2, 3, 5);
    rd_chk("R4 tx3 credits back", a_of(0, 3, 0), 32'd2);
  endtask

  task automatic t_ignored;
    wr(a_of(0, 0, 0), 32'h0);
    wr(a_of(1, 0, 0), 32'h8000_0000);
    wr(a_of(0, 2, 15), 32'h1234_5678);
    wr(a_of(0, 3, 15) | ADDR_W'(1), 32'h1);
    rd_chk("R11 status write ignored", a_of(0, 0, 0), 32'h8000_0002);
    rd_chk("R11 ctrl write ignored", a_of(1, 0, 0), 32'h0);
    rd_chk("R11 rx data write ignored", a_of(0, 2, 0), 32'd0);
    rd_chk("R11 misaligned commit ignored", a_of(0, 3, 0), 32'd2);
    rd_chk("R11 tx data reads zero", a_of(0, 3, 1), 32'h0);
    rd_chk("R11 misaligned read zero", a_of(0, 0, 0) | ADDR_W'(2), 32'h0);
    chk("R11 irq unchanged", 32'(rx_irq), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_backpressure;
    t_direction;
    t_send;
    t_overflow;
    t_receive;
    t_underflow;
    t_pair_b;
    t_ignored;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule